// File: doc/BRIEF.md
# Master-Side Address Decoder with Access Guard

This block sits on the master side of a multi-layer AHB interconnect, one instance per master. During each address phase it decodes the master's address into a one-hot select over a fixed set of slave regions. It then decides whether the transfer may go ahead. The decision uses this master's permission entry for the target slave, the master enable input and, for the instance marked as the fabric master, a protected address window. A permitted transfer is forwarded by asserting the select for its slave stage. For a forwarded data phase, the slave stage's ready and response are passed back to the master.

A refused transfer never reaches a slave. The block finishes it locally with the two-cycle AHB error response. It also sets a sticky error flag, which software clears through a write-one-to-clear strobe. IDLE and BUSY transfers are answered locally with a zero-wait OKAY.

Region bases and masks, the permission entries, the protected window and the fabric flag are all parameters. Each permission entry is two bits: `00` means no access, `01` means read-only, `11` means read-write, and `10` is treated as no access.

Top module: `ahb_mstage_guard`

## Requirements
- R1: When an accepted NONSEQ or SEQ transfer (htrans_i = 2'b10 or 2'b11) is permitted, `slv_sel_o` has exactly one bit set in the same cycle. That bit is the lowest index i for which (haddr_i & mask[i]) == base[i].
- R2: A write is refused unless the target slave's permission entry is `11`.
- R3: A read is refused when the target slave's permission entry is `00` or `10`. Entries `01` and `11` permit reads.
- R4: A read or write whose address matches no slave region is refused.
- R5: While `master_en_i` is low, every NONSEQ or SEQ transfer is refused at any address.
- R6: With the fabric flag set, a read or write inside the protected window is refused, even when the region and the permission would allow it.
- R7: In the first cycle after a refused transfer is accepted, `hready_o` is 0 and `hresp_o` is 1. In the next cycle `hready_o` is 1 and `hresp_o` is 1.
- R8: Acceptance of a refused transfer sets `err_sticky_o` from the next cycle. The flag holds until it is cleared. A set in the same cycle as a clear wins.
- R9: A high `err_clr_i` with no set pending clears `err_sticky_o` from the next cycle.
- R10: A refused transfer, and any IDLE (2'b00) or BUSY (2'b01) transfer, drives `slv_sel_o` to zero. IDLE and BUSY get `hready_o`=1 and `hresp_o`=0 in the following cycle and never set the error flag.
- R11: During a forwarded data phase, `hready_o` and `hresp_o` follow `hready_i` and `hresp_i` until `hready_i` is high.
- R12: In reset, `hready_o` is 1, `hresp_o` is 0 and `err_sticky_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| haddr_i | input | ADDR_W | Master address |
| htrans_i | input | 2 | Master transfer type |
| hwrite_i | input | 1 | Master write flag |
| hready_i | input | 1 | Ready from the selected slave stage |
| hresp_i | input | 1 | Error response from the selected slave stage |
| master_en_i | input | 1 | Master enable; low refuses all accesses |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the sticky flag |
| slv_sel_o | output | NUM_SLV | One-hot slave select |
| hready_o | output | 1 | Ready returned to the master |
| hresp_o | output | 1 | Error response returned to the master |
| err_sticky_o | output | 1 | Sticky access-error flag |

## Verification
The checks assume the slave stage follows the AHB rules on its own side. A slave that raises `hresp_i` with `hready_i` low must raise `hready_i` with `hresp_i` still high in the next cycle. The checks also assume the master drives only the four defined transfer codes. The stimulus drives slave responses only as legal two-cycle pairs or as plain wait states. It returns the master to IDLE as soon as each address phase has been accepted, so no new transfer is presented while an error response is in progress.

// File: rtl/mstage_pkg.sv
package mstage_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;

  // owner of the current data phase
  typedef enum logic [1:0] {
    DPH_LOCAL = 2'b00,
    DPH_FWD   = 2'b01,
    DPH_ERR1  = 2'b10,
    DPH_ERR2  = 2'b11
  } dph_e;

endpackage

// File: rtl/mstage_addr_dec.sv
module mstage_addr_dec #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_SLV = 4,
  parameter logic [NUM_SLV-1:0][ADDR_W-1:0] SLV_BASE = '0,
  parameter logic [NUM_SLV-1:0][ADDR_W-1:0] SLV_MASK = '0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_SLV-1:0] hit_oh_o,
  output logic               any_hit_o
);

  logic [NUM_SLV-1:0] raw_hit;

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_region
    assign raw_hit[g] = ((addr_i & SLV_MASK[g]) == SLV_BASE[g]);
  end

  // lowest index wins on overlap
  always_comb begin
    logic found;
    found    = 1'b0;
    hit_oh_o = '0;
    for (int i = 0; i < int'(NUM_SLV); i++) begin
      if (raw_hit[i] && !found) begin
        hit_oh_o[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign any_hit_o = |raw_hit;

endmodule

// File: rtl/mstage_perm_chk.sv
module mstage_perm_chk
  import mstage_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_SLV = 4,
  parameter logic [NUM_SLV-1:0][1:0] SLV_PERM = '0,
  parameter bit          IS_FABRIC = 1'b0,
  parameter logic [ADDR_W-1:0] PROT_BASE = '0,
  parameter logic [ADDR_W-1:0] PROT_MASK = '0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               write_i,
  input  logic               en_i,
  input  logic [NUM_SLV-1:0] hit_oh_i,
  input  logic               any_hit_i,
  output logic               refuse_o
);

  logic [1:0] perm_sel;
  logic       prot_hit;
  logic       rd_ok;
  logic       wr_ok;

  always_comb begin
    perm_sel = '0;
    for (int i = 0; i < int'(NUM_SLV); i++) begin
      perm_sel |= {2{hit_oh_i[i]}} & SLV_PERM[i];
    end
  end

  if (IS_FABRIC) begin : g_prot
    assign prot_hit = ((addr_i & PROT_MASK) == PROT_BASE);
  end else begin : g_noprot
    assign prot_hit = 1'b0;
  end

  assign wr_ok = (perm_sel == PERM_RW);
  assign rd_ok = (perm_sel == PERM_RO) || (perm_sel == PERM_RW);

  assign refuse_o = !en_i || !any_hit_i || prot_hit ||
                    (write_i ? !wr_ok : !rd_ok);

endmodule

// File: rtl/mstage_resp_fsm.sv
module mstage_resp_fsm
  import mstage_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic refuse_i,
  input  logic hready_i,
  input  logic hresp_i,
  output logic hready_o,
  output logic hresp_o,
  output logic err_set_o,
  output dph_e dph_o
);

  dph_e dph_q, dph_d;

  always_comb begin
    unique case (dph_q)
      DPH_FWD:  begin hready_o = hready_i; hresp_o = hresp_i; end
      DPH_ERR1: begin hready_o = 1'b0;     hresp_o = 1'b1;    end
      DPH_ERR2: begin hready_o = 1'b1;     hresp_o = 1'b1;    end
      default:  begin hready_o = 1'b1;     hresp_o = 1'b0;    end
    endcase
  end

  always_comb begin
    dph_d = dph_q;
    if (hready_o) begin
      if (active_i) dph_d = refuse_i ? DPH_ERR1 : DPH_FWD;
      else          dph_d = DPH_LOCAL;
    end else if (dph_q == DPH_ERR1) begin
      dph_d = DPH_ERR2;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dph_q <= DPH_LOCAL;
    else         dph_q <= dph_d;
  end

  assign err_set_o = hready_o && active_i && refuse_i;
  assign dph_o     = dph_q;

endmodule

// File: rtl/ahb_mstage_guard.sv
module ahb_mstage_guard
  import mstage_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_SLV = 4,
  parameter logic [NUM_SLV-1:0][ADDR_W-1:0] SLV_BASE =
    {32'h6000_0000, 32'h4000_0000, 32'h2000_0000, 32'h0000_0000},
  parameter logic [NUM_SLV-1:0][ADDR_W-1:0] SLV_MASK =
    {32'hFFFF_0000, 32'hF000_0000, 32'hF000_0000, 32'hF000_0000},
  parameter logic [NUM_SLV-1:0][1:0] SLV_PERM = {2'b11, 2'b00, 2'b01, 2'b11},
  parameter bit          IS_FABRIC = 1'b1,
  parameter logic [ADDR_W-1:0] PROT_BASE = 32'h0000_F000,
  parameter logic [ADDR_W-1:0] PROT_MASK = 32'hFFFF_F000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  haddr_i,
  input  logic [1:0]         htrans_i,
  input  logic               hwrite_i,
  input  logic               hready_i,
  input  logic               hresp_i,
  input  logic               master_en_i,
  input  logic               err_clr_i,
  output logic [NUM_SLV-1:0] slv_sel_o,
  output logic               hready_o,
  output logic               hresp_o,
  output logic               err_sticky_o
);

  logic [NUM_SLV-1:0] hit_oh;
  logic               any_hit;
  logic               refuse;
  logic               active;
  logic               err_set;
  logic               sticky_q;
  dph_e               dph_q;

  assign active = (htrans_i == TRANS_NONSEQ) || (htrans_i == TRANS_SEQ);

  mstage_addr_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_SLV (NUM_SLV),
    .SLV_BASE(SLV_BASE),
    .SLV_MASK(SLV_MASK)
  ) u_dec (
    .addr_i   (haddr_i),
    .hit_oh_o (hit_oh),
    .any_hit_o(any_hit)
  );

  mstage_perm_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_SLV  (NUM_SLV),
    .SLV_PERM (SLV_PERM),
    .IS_FABRIC(IS_FABRIC),
    .PROT_BASE(PROT_BASE),
    .PROT_MASK(PROT_MASK)
  ) u_chk (
    .addr_i   (haddr_i),
    .write_i  (hwrite_i),
    .en_i     (master_en_i),
    .hit_oh_i (hit_oh),
    .any_hit_i(any_hit),
    .refuse_o (refuse)
  );

  mstage_resp_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .refuse_i (refuse),
    .hready_i (hready_i),
    .hresp_i  (hresp_i),
    .hready_o (hready_o),
    .hresp_o  (hresp_o),
    .err_set_o(err_set),
    .dph_o    (dph_q)
  );

  // no forward while the first error cycle stalls the master
  assign slv_sel_o = hit_oh & {NUM_SLV{active && !refuse && (dph_q != DPH_ERR1)}};

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sticky_q <= 1'b0;
    else if (err_set)   sticky_q <= 1'b1;
    else if (err_clr_i) sticky_q <= 1'b0;
  end

  assign err_sticky_o = sticky_q;

endmodule

// File: rtl/ahb_mstage_guard_chk.sv
module ahb_mstage_guard_chk
  import mstage_pkg::*;
#(
  parameter int unsigned NUM_SLV = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         htrans_i,
  input logic               master_en_i,
  input logic               err_clr_i,
  input logic [NUM_SLV-1:0] slv_sel_o,
  input logic               hready_o,
  input logic               hresp_o,
  input logic               err_sticky_o,
  input dph_e               dph_q
);

  p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slv_sel_o));

  p_disabled_no_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en_i |-> (slv_sel_o == '0));

  p_idle_no_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_i == TRANS_IDLE || htrans_i == TRANS_BUSY) |-> (slv_sel_o == '0));

  p_err_second_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hready_o && hresp_o) |=> (hready_o && hresp_o));

  p_err_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dph_q == DPH_ERR1) |-> err_sticky_o);

  p_sticky_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_sticky_o && !err_clr_i) |=> err_sticky_o);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && dph_q != DPH_ERR1 && hready_o && htrans_i == TRANS_IDLE) |=> !err_sticky_o);

endmodule

bind ahb_mstage_guard ahb_mstage_guard_chk #(.NUM_SLV(NUM_SLV)) u_guard_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .htrans_i    (htrans_i),
  .master_en_i (master_en_i),
  .err_clr_i   (err_clr_i),
  .slv_sel_o   (slv_sel_o),
  .hready_o    (hready_o),
  .hresp_o     (hresp_o),
  .err_sticky_o(err_sticky_o),
  .dph_q       (dph_q)
);

// File: tb/ahb_mstage_guard_tb_top.sv
`timescale 1ns/1ps
module ahb_mstage_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic        hready_s = 1'b1;
  logic        hresp_s = 1'b0;
  logic        men = 1'b1;
  logic        eclr = 1'b0;
  logic [3:0]  sel;
  logic        hready_m;
  logic        hresp_m;
  logic        sticky;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ahb_mstage_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hready_i(hready_s), .hresp_i(hresp_s),
    .master_en_i(men), .err_clr_i(eclr), .slv_sel_o(sel),
    .hready_o(hready_m), .hresp_o(hresp_m), .err_sticky_o(sticky)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        en;
    logic [3:0]  sel;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 1'b0, 1'b1, 4'b0001, 1'b0, 4'd1},  // R1 read RW slave
    '{32'h0000_0100, 1'b1, 1'b1, 4'b0001, 1'b0, 4'd2},  // R2 write RW slave
    '{32'h2000_0040, 1'b0, 1'b1, 4'b0010, 1'b0, 4'd3},  // R3 read RO slave
    '{32'h2000_0040, 1'b1, 1'b1, 4'b0000, 1'b1, 4'd2},  // R2 write RO slave
    '{32'h4000_0000, 1'b0, 1'b1, 4'b0000, 1'b1, 4'd3},  // R3 read NONE slave
    '{32'h4000_0000, 1'b1, 1'b1, 4'b0000, 1'b1, 4'd2},  // R2 write NONE slave
    '{32'h6000_1234, 1'b0, 1'b1, 4'b1000, 1'b0, 4'd1},  // R1 small region
    '{32'h6001_0000, 1'b0, 1'b1, 4'b0000, 1'b1, 4'd4},  // R4 just past region
    '{32'h8000_0000, 1'b1, 1'b1, 4'b0000, 1'b1, 4'd4},  // R4 unmapped write
    '{32'h0000_F010, 1'b0, 1'b1, 4'b0000, 1'b1, 4'd6},  // R6 protected read
    '{32'h0000_FFFC, 1'b1, 1'b1, 4'b0000, 1'b1, 4'd6},  // R6 protected write
    '{32'h0000_EFFC, 1'b0, 1'b1, 4'b0001, 1'b0, 4'd6},  // R6 below window
    '{32'h0000_0100, 1'b0, 1'b0, 4'b0000, 1'b1, 4'd5},  // R5 disabled read
    '{32'h6000_0000, 1'b1, 1'b0, 4'b0000, 1'b1, 4'd5}   // R5 disabled write
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_flag();
    eclr = 1'b1;
    cyc();
    eclr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R12 reset state
    #12;
    chk("R12", "hready", {31'b0, hready_m}, 32'd1);
    chk("R12", "hresp", {31'b0, hresp_m}, 32'd0);
    chk("R12", "sticky", {31'b0, sticky}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // vector walk
    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[v].req);
      haddr = VECS[v].addr; hwrite = VECS[v].wr; men = VECS[v].en;
      htrans = 2'b10;
      #1;
      chk(rq, "sel", {28'b0, sel}, {28'b0, VECS[v].sel});
      @(posedge clk); @(negedge clk);
      htrans = 2'b00;
      if (VECS[v].err) begin
        chk("R7", "err1 hready", {31'b0, hready_m}, 32'd0);
        chk("R7", "err1 hresp", {31'b0, hresp_m}, 32'd1);
        chk("R8", "sticky set", {31'b0, sticky}, 32'd1);
        #1;
        chk("R10", "no sel in err", {28'b0, sel}, 32'd0);
        cyc();
        chk("R7", "err2 hready", {31'b0, hready_m}, 32'd1);
        chk("R7", "err2 hresp", {31'b0, hresp_m}, 32'd1);
      end else begin
        chk("R11", "fwd hready", {31'b0, hready_m}, 32'd1);
        chk("R11", "fwd hresp", {31'b0, hresp_m}, 32'd0);
        chk(rq, "sticky clear", {31'b0, sticky}, 32'd0);
      end
      cyc();
      chk(rq, "idle hresp", {31'b0, hresp_m}, 32'd0);
      if (VECS[v].err) begin
        clr_flag();
        chk("R9", "cleared", {31'b0, sticky}, 32'd0);
      end
      men = 1'b1;
    end

    // R10 BUSY and IDLE to a legal address
    haddr = 32'h0000_0100; hwrite = 1'b0;
    htrans = 2'b01;
    #1;
    chk("R10", "busy sel", {28'b0, sel}, 32'd0);
    cyc();
    chk("R10", "busy hready", {31'b0, hready_m}, 32'd1);
    chk("R10", "busy hresp", {31'b0, hresp_m}, 32'd0);
    chk("R10", "busy sticky", {31'b0, sticky}, 32'd0);
    htrans = 2'b00;
    #1;
    chk("R10", "idle sel", {28'b0, sel}, 32'd0);
    cyc();
    chk("R10", "idle sticky", {31'b0, sticky}, 32'd0);

    // R11 wait states then slave error passed through
    hready_s = 1'b0; hresp_s = 1'b0;
    htrans = 2'b11;  // SEQ
    #1;
    chk("R1", "seq sel", {28'b0, sel}, 32'd1);
    cyc();
    htrans = 2'b00;
    chk("R11", "wait hready", {31'b0, hready_m}, 32'd0);
    cyc();
    chk("R11", "wait2 hready", {31'b0, hready_m}, 32'd0);
    hresp_s = 1'b1;
    #1;
    chk("R11", "slv err1 hresp", {31'b0, hresp_m}, 32'd1);
    chk("R11", "slv err1 hready", {31'b0, hready_m}, 32'd0);
    cyc();
    hready_s = 1'b1;
    #1;
    chk("R11", "slv err2 hready", {31'b0, hready_m}, 32'd1);
    chk("R11", "slv err2 hresp", {31'b0, hresp_m}, 32'd1);
    chk("R11", "slv err no flag", {31'b0, sticky}, 32'd0);
    cyc();
    hresp_s = 1'b0;
    cyc();

    // R8 set wins over a simultaneous clear
    haddr = 32'h8000_0000; htrans = 2'b10; eclr = 1'b1;
    cyc();
    htrans = 2'b00; eclr = 1'b0;
    chk("R8", "set beats clear", {31'b0, sticky}, 32'd1);
    cyc();
    cyc();
    chk("R8", "flag holds", {31'b0, sticky}, 32'd1);
    clr_flag();
    chk("R9", "clear strobe", {31'b0, sticky}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule